// File: doc/BRIEF.md
# NAND Bus Timing Strobe Generator

This block produces the chip-enable, read-enable and write-enable strobes for one single-beat access to a NAND flash device. A requester raises a valid request that names the direction and whether the access must wait for the device's ready/busy line afterwards. The block then steps through a fixed sequence of phases. Each phase length is a count of system clock cycles taken from one packed 32-bit timing word.

The sequence is: chip-enable lead-in, strobe low, strobe high, an optional busy delay followed by a wait for ready, and a turnaround gap with chip enable released. A read gives a one-cycle capture pulse as read-enable rises. Every access ends with a one-cycle done pulse. The timing word is a plain input port and is latched when a request is accepted. Requests are accepted only while the block is idle, through a valid/ready handshake.

Top module: `nand_strobe_gen`

## Requirements
- R1: While reset is asserted, and from then until the first request, ce_n, re_n and we_n are high, cap_pulse and done_pulse are low, and req_ready is high. Reset takes effect asynchronously, also in the middle of an access.
- R2: Each timing field is an unsigned cycle count, and a field value of zero gives a phase of one cycle.
- R3: After a request is accepted, ce_n goes low and stays low for max(1, cfg[25:24]) cycles before the access strobe goes low.
- R4: The write strobe we_n is low for max(1, cfg[3:0]) cycles and the read strobe re_n is low for max(1, cfg[11:8]) cycles. Only the strobe that belongs to the request direction (req_write = 1 selects write) ever goes low.
- R5: For a request without the wait flag, ce_n stays low for max(1, cfg[7:4]) cycles after we_n rises, or max(1, cfg[15:12]) cycles after re_n rises.
- R6: A read produces exactly one cap_pulse, in the first cycle in which re_n is high again. A write produces none.
- R7: After ce_n rises, ce_n stays high for max(1, cfg[18:16]) cycles. Then done_pulse is high for exactly one cycle, in the same cycle that req_ready returns high.
- R8: For a request with req_wait_rb = 1, the high phase is followed by max(1, cfg[23:19]) further cycles with ce_n low. ce_n then stays low until ready is seen on rb_n (1 = ready). rb_n passes through two synchroniser flops, so ce_n rises in the third cycle after rb_n goes high.
- R9: req_ready is low from the acceptance of a request until done_pulse. A request held valid during an access is not accepted until then.
- R10: The timing word is captured at acceptance, and changing cfg_word during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_wait_rb | input | 1 | Apply the busy delay and wait for ready after the strobe |
| req_ready | output | 1 | Block is idle and accepts a request |
| cfg_word | input | 32 | Packed phase lengths |
| rb_n | input | 1 | Device ready/busy, 1 = ready (asynchronous) |
| ce_n | output | 1 | Chip enable, active low |
| re_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| cap_pulse | output | 1 | Read data capture pulse |
| done_pulse | output | 1 | Access complete pulse |

## Verification
A wrong phase counter or state shows at the ports as a strobe edge that is off by whole cycles. The bench measures each phase edge to edge, so one cycle too early or too late fails the phase in which it happens. A corrupted direction shows as the wrong strobe going low or a capture pulse on a write, both visible within the access. A broken ready synchroniser shows as ce_n rising at the wrong distance from the rb_n release.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

  localparam int CNT_W = 5;

  // bit positions of the packed timing word
  localparam int WR_LO_LSB = 0;
  localparam int WR_HI_LSB = 4;
  localparam int RD_LO_LSB = 8;
  localparam int RD_HI_LSB = 12;
  localparam int TA_LSB    = 16;
  localparam int BUSY_LSB  = 19;
  localparam int CEA_LSB   = 24;

  // counter load values (phase length minus one)
  typedef struct packed {
    logic [CNT_W-1:0] cea;
    logic [CNT_W-1:0] wr_lo;
    logic [CNT_W-1:0] wr_hi;
    logic [CNT_W-1:0] rd_lo;
    logic [CNT_W-1:0] rd_hi;
    logic [CNT_W-1:0] ta;
    logic [CNT_W-1:0] busy;
  } nsg_timing_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CEA  = 3'd1,
    S_LOW  = 3'd2,
    S_HIGH = 3'd3,
    S_BUSY = 3'd4,
    S_WAIT = 3'd5,
    S_TURN = 3'd6
  } nsg_state_t;

endpackage

// File: rtl/nsg_sync2.sv
module nsg_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/nsg_cfg_decode.sv
module nsg_cfg_decode
  import nsg_pkg::*;
(
  input  logic [31:0]  cfg_word,
  output nsg_timing_t  tim
);
  // zero and one both give a single-cycle phase
  function automatic logic [CNT_W-1:0] to_load(input logic [CNT_W-1:0] f);
    return (f == '0) ? '0 : f - 1'b1;
  endfunction

  always_comb begin
    tim.wr_lo = to_load(CNT_W'(cfg_word[WR_LO_LSB +: 4]));
    tim.wr_hi = to_load(CNT_W'(cfg_word[WR_HI_LSB +: 4]));
    tim.rd_lo = to_load(CNT_W'(cfg_word[RD_LO_LSB +: 4]));
    tim.rd_hi = to_load(CNT_W'(cfg_word[RD_HI_LSB +: 4]));
    tim.ta    = to_load(CNT_W'(cfg_word[TA_LSB    +: 3]));
    tim.busy  = to_load(CNT_W'(cfg_word[BUSY_LSB  +: 5]));
    tim.cea   = to_load(CNT_W'(cfg_word[CEA_LSB   +: 2]));
  end
endmodule

// File: rtl/nsg_phase_timer.sv
module nsg_phase_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R2: once loaded, the count moves down by exactly one per cycle
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nsg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_wait_rb,
  output logic        req_ready,
  input  logic [31:0] cfg_word,
  input  logic        rb_n,
  output logic        ce_n,
  output logic        re_n,
  output logic        we_n,
  output logic        cap_pulse,
  output logic        done_pulse
);
  logic        rst_sync_n;
  logic        rb_ok;
  nsg_timing_t tim_live, tim_q;
  nsg_state_t  state_q, state_d;
  logic        wr_q, wait_q;
  logic        accept;
  logic        t_load, t_expired;
  logic [CNT_W-1:0] t_val;
  logic        ce_n_q, re_n_q, we_n_q, cap_q, done_q;
  logic        ce_n_d, re_n_d, we_n_d, cap_d, done_d;

  // reset asserts at once and releases on a clock edge
  nsg_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  nsg_sync2 #(.RST_VAL(1'b0)) u_rb_sync (
    .clk(clk), .arst_n(rst_sync_n), .d(rb_n), .q(rb_ok)
  );

  nsg_cfg_decode u_dec (.cfg_word(cfg_word), .tim(tim_live));

  nsg_phase_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .load(t_load), .load_val(t_val),
    .expired(t_expired)
  );

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_ready && req_valid;

  // next-state and phase timer load
  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      S_IDLE: if (req_valid) begin
        state_d = S_CEA;  t_load = 1'b1; t_val = tim_live.cea;
      end
      S_CEA: if (t_expired) begin
        state_d = S_LOW;  t_load = 1'b1; t_val = wr_q ? tim_q.wr_lo : tim_q.rd_lo;
      end
      S_LOW: if (t_expired) begin
        state_d = S_HIGH; t_load = 1'b1; t_val = wr_q ? tim_q.wr_hi : tim_q.rd_hi;
      end
      S_HIGH: if (t_expired) begin
        t_load = 1'b1;
        if (wait_q) begin state_d = S_BUSY; t_val = tim_q.busy; end
        else        begin state_d = S_TURN; t_val = tim_q.ta;   end
      end
      S_BUSY: if (t_expired) begin
        if (rb_ok) begin state_d = S_TURN; t_load = 1'b1; t_val = tim_q.ta; end
        else           state_d = S_WAIT;
      end
      S_WAIT: if (rb_ok) begin
        state_d = S_TURN; t_load = 1'b1; t_val = tim_q.ta;
      end
      S_TURN: if (t_expired) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // registered outputs decoded from the next state
  always_comb begin
    ce_n_d = !((state_d == S_CEA) || (state_d == S_LOW) || (state_d == S_HIGH) ||
               (state_d == S_BUSY) || (state_d == S_WAIT));
    re_n_d = !((state_d == S_LOW) && !wr_q);
    we_n_d = !((state_d == S_LOW) &&  wr_q);
    cap_d  = (state_q == S_LOW) && (state_d == S_HIGH) && !wr_q;
    done_d = (state_q == S_TURN) && (state_d == S_IDLE);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_IDLE;
      ce_n_q  <= 1'b1;
      re_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      cap_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= ce_n_d;
      re_n_q  <= re_n_d;
      we_n_q  <= we_n_d;
      cap_q   <= cap_d;
      done_q  <= done_d;
    end
  end

  // request attributes and timing captured only on acceptance
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_q   <= 1'b0;
      wait_q <= 1'b0;
      tim_q  <= '0;
    end else if (accept) begin
      wr_q   <= req_write;
      wait_q <= req_wait_rb;
      tim_q  <= tim_live;
    end
  end

  assign ce_n       = ce_n_q;
  assign re_n       = re_n_q;
  assign we_n       = we_n_q;
  assign cap_pulse  = cap_q;
  assign done_pulse = done_q;

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(!re_n && !we_n));

  a_r3_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!re_n || !we_n) |-> !ce_n);

  a_r6_cap_on_re_rise: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_pulse |-> (re_n && $past(!re_n)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_pulse |=> !done_pulse);

  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready |-> (ce_n && re_n && we_n));

  a_r8_wait_holds_ce: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state_q == S_WAIT) && !rb_ok) |=> !ce_n);
endmodule

// File: tb/tb_nand_strobe_gen.sv
module tb_nand_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_wait_rb, req_ready;
  logic [31:0] cfg_word;
  logic        rb_n;
  logic        ce_n, re_n, we_n, cap_pulse, done_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #10 clk = ~clk;

  nand_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wait_rb(req_wait_rb), .req_ready(req_ready), .cfg_word(cfg_word),
    .rb_n(rb_n), .ce_n(ce_n), .re_n(re_n), .we_n(we_n),
    .cap_pulse(cap_pulse), .done_pulse(done_pulse)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired before the run ended (R1..R10 unfinished)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ef(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // {write, wait_flag, cfg_word}
  localparam logic [33:0] VEC [0:5] = '{
    {1'b0, 1'b0, 32'h0201_2365},
    {1'b1, 1'b0, 32'h0303_0024},
    {1'b0, 1'b0, 32'h0000_0000},
    {1'b1, 1'b0, 32'h0307_00FF},
    {1'b1, 1'b1, 32'h012A_0012},
    {1'b0, 1'b1, 32'h00F8_0F00}
  };

  int m_cea, m_low, m_post, m_turn, m_cap, m_cap_ok, m_other, m_rdy_bad, m_done, m_rel;

  task automatic run_op(input logic wr, input logic wt, input logic [31:0] cfg,
                        input logic hold, input int rel_at, input logic [31:0] cfg_mid);
    int ph;
    int rel_idx;
    logic s_lo, o_lo;
    m_cea = 0; m_low = 0; m_post = 0; m_turn = 0; m_cap = 0; m_cap_ok = 0;
    m_other = 0; m_rdy_bad = 0; m_done = 0; m_rel = -1;
    ph = 0; rel_idx = -1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wait_rb = wt; cfg_word = cfg;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (i == 0) begin
        cfg_word = cfg_mid;
        if (!hold) req_valid = 1'b0;
      end
      s_lo = wr ? !we_n : !re_n;
      o_lo = wr ? !re_n : !we_n;
      if (o_lo) m_other++;
      if (cap_pulse) begin
        m_cap++;
        if (ph == 1 && !s_lo) m_cap_ok = 1;
      end
      if (done_pulse) begin
        m_done = 1;
        req_valid = 1'b0;
        break;
      end
      if (req_ready) m_rdy_bad++;
      if (s_lo) begin ph = 1; m_low++; end
      else if (!ce_n && ph == 0) m_cea++;
      else if (!ce_n) begin ph = 2; m_post++; end
      else begin
        m_turn++;
        if (rel_idx >= 0 && m_rel < 0) m_rel = i - rel_idx;
      end
      if (i == rel_at) begin rb_n = 1'b1; rel_idx = i; end
    end
  endtask

  initial begin
    logic [33:0] v;
    logic [31:0] c;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_wait_rb = 1'b0;
    cfg_word = '0; rb_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: values held in reset
    chk("R1 ce_n in reset", ce_n, 1);
    chk("R1 re_n in reset", re_n, 1);
    chk("R1 we_n in reset", we_n, 1);
    chk("R1 pulses in reset", cap_pulse + done_pulse, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 ce_n idle", ce_n, 1);

    // table walk
    for (int k = 0; k < 6; k++) begin
      v = VEC[k];
      c = v[31:0];
      run_op(v[33], v[32], c, 1'b0, -1, c);
      chk($sformatf("R7 done seen vec%0d", k), m_done, 1);
      chk($sformatf("R3 ce lead vec%0d", k), m_cea, ef(int'(c[25:24])));
      chk($sformatf("R4 strobe low vec%0d", k), m_low,
          v[33] ? ef(int'(c[3:0])) : ef(int'(c[11:8])));
      chk($sformatf("R4 other strobe vec%0d", k), m_other, 0);
      if (v[32])
        chk($sformatf("R8 post with busy vec%0d", k), m_post,
            (v[33] ? ef(int'(c[7:4])) : ef(int'(c[15:12]))) + ef(int'(c[23:19])));
      else
        chk($sformatf("R5 post high vec%0d", k), m_post,
            v[33] ? ef(int'(c[7:4])) : ef(int'(c[15:12])));
      chk($sformatf("R7 turnaround vec%0d", k), m_turn, ef(int'(c[18:16])));
      chk($sformatf("R6 cap count vec%0d", k), m_cap, v[33] ? 0 : 1);
      if (!v[33]) chk($sformatf("R6 cap position vec%0d", k), m_cap_ok, 1);
      chk($sformatf("R9 ready low vec%0d", k), m_rdy_bad, 0);
      chk($sformatf("R7 ready with done vec%0d", k), req_ready, 1);
      @(negedge clk);
      chk($sformatf("R7 done single vec%0d", k), done_pulse, 0);
    end

    // R2: all-zero read already walked; zero write too
    run_op(1'b1, 1'b1, 32'h0, 1'b0, -1, 32'h0);
    chk("R2 zero fields lead", m_cea, 1);
    chk("R2 zero fields low", m_low, 1);
    chk("R2 zero fields post", m_post, 2);
    chk("R2 zero fields turn", m_turn, 1);

    // R8: device busy, released while waiting
    rb_n = 1'b0;
    repeat (4) @(negedge clk);
    run_op(1'b1, 1'b1, 32'h0110_0011, 1'b0, 20, 32'h0110_0011);
    chk("R8 ce rise after rb release", m_rel, 3);
    chk("R8 ce low while busy", (m_cea + m_low + m_post) >= 21 ? 1 : 0, 1);
    chk("R8 turnaround", m_turn, 1);

    // R10: timing word changed mid-access
    run_op(1'b0, 1'b0, 32'h0102_1200, 1'b0, -1, 32'hFFFF_FFFF);
    chk("R10 lead kept", m_cea, 1);
    chk("R10 low kept", m_low, 2);
    chk("R10 high kept", m_post, 1);
    chk("R10 turn kept", m_turn, 2);

    // R9: valid held through an access
    run_op(1'b1, 1'b0, 32'h0102_0033, 1'b1, -1, 32'h0102_0033);
    chk("R9 ready low while held", m_rdy_bad, 0);
    chk("R9 low phase held req", m_low, 3);
    repeat (3) @(negedge clk);
    chk("R9 no second access", ce_n, 1);

    // R1: reset in the middle of an access
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_wait_rb = 1'b0; cfg_word = 32'h0307_00FF;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 access running", we_n, 0);
    rst_n = 1'b0;
    #1;
    chk("R1 async ce_n", ce_n, 1);
    chk("R1 async we_n", we_n, 1);
    chk("R1 async ready", req_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", ce_n, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule